// File: doc/BRIEF.md
# Dual-Edge Kicked Watchdog Timer

This block watches a single activity signal driven by software. Any change of level on that signal, whether low-to-high or high-to-low, counts as a kick and restarts a timeout counter that runs on the block clock. If the counter reaches the end of its interval with no kick, the active-low watchdog output is pulled low. The counter then reloads and keeps timing.

Once the output is low, it stays low until the next kick. That kick releases the output and starts a fresh interval. An enable input lets the system switch supervision off. While it is off, the counter is held at zero and the output is held high.

The interval is a parameter counted in clock cycles. Its default is 1.6 s at a 32.768 kHz clock. The activity signal may be asynchronous to the clock, so it passes through a two-stage synchronizer before edges are detected.

Top module: `wdog_edge_timer`

## Requirements
- R1: A low-to-high change on `kick_in` is a kick. It clears the counter and drives `wdo_n` high.
- R2: A high-to-low change on `kick_in` is also a kick, with the same effect as in R1.
- R3: If `enable` is 1 and no kick arrives, `wdo_n` goes low exactly TIMEOUT_CYCLES clock edges after the edge that last cleared the counter.
- R4: On expiry the counter reloads to zero and starts counting again. `wdo_n` remains low through any later expiries.
- R5: After `wdo_n` goes low, it stays low until a kick takes effect.
- R6: While `enable` is 0, the counter is held at zero and `wdo_n` is high. When `enable` returns to 1, a full TIMEOUT_CYCLES interval starts from zero.
- R7: While `rst` is 1 at a clock edge, the counter is cleared and `wdo_n` is high. After release, counting starts from zero.
- R8: If a kick takes effect on the same edge as an expiry, the kick wins. `wdo_n` stays high and the counter restarts from zero.
- R9: A change on `kick_in` takes effect on the third rising clock edge after it occurs: two synchronizer stages, then the counter update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| kick_in | input | 1 | Activity signal; either edge is a kick |
| enable | input | 1 | 1 = supervision on, 0 = counter held and output released |
| wdo_n | output | 1 | Watchdog expiry flag, active low |

## Verification
The hardest case to reach is a kick that lands on exactly the edge where the counter would otherwise expire. Because the synchronizer adds latency, the activity signal has to toggle three edges before the expiry edge. The bench counts those edges from the last clearing event to place the toggle there.

The bench also sweeps the gap between kicks from zero to beyond twice the interval, with the kick polarity alternating. This covers early kicks, the last safe cycle, and expiry followed by a reload.

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer #(
  parameter int TIMEOUT_CYCLES = 52429
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_in,
  input  logic enable,
  output logic wdo_n
);
  localparam int CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] cnt;
  logic          kick_edge;
  logic          expire;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[0], kick_in};
    prev_q <= sync_q[1];
  end

  assign kick_edge = sync_q[1] ^ prev_q;
  assign expire    = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt   <= '0;
      wdo_n <= 1'b1;
    end else if (kick_edge) begin
      cnt   <= '0;
      wdo_n <= 1'b1;
    end else if (expire) begin
      cnt   <= '0;
      wdo_n <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_edge_timer_chk.sv
module wdog_edge_timer_chk #(
  parameter int LIMIT = 2,
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          kick_edge,
  input logic [CW-1:0] cnt,
  input logic          wdo_n
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (wdo_n && cnt == '0));

  a_r6_disable_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (wdo_n && cnt == '0));

  a_r8_kick_wins: assert property (@(posedge clk) disable iff (rst)
    (enable && kick_edge) |=> (wdo_n && cnt == '0));

  a_r4_reload_on_expiry: assert property (@(posedge clk) disable iff (rst)
    (enable && !kick_edge && cnt == LAST) |=> (cnt == '0 && !wdo_n));

  a_r3_counts_up: assert property (@(posedge clk) disable iff (rst)
    (enable && !kick_edge && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
    (enable && !kick_edge && !wdo_n) |=> !wdo_n);
endmodule

bind wdog_edge_timer wdog_edge_timer_chk #(.LIMIT(TIMEOUT_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .kick_edge(kick_edge),
  .cnt(cnt), .wdo_n(wdo_n)
);

// File: tb/wdog_edge_timer_test.sv
module wdog_edge_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_in = 1'b0;
  logic enable = 1'b1;
  logic wdo_n;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int zero = 0;
  bit rst_m = 1'b1;
  bit en_m = 1'b1;

  wdog_edge_timer #(.TIMEOUT_CYCLES(T)) uut (
    .clk(clk), .rst(rst), .kick_in(kick_in), .enable(enable), .wdo_n(wdo_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag);
    logic expv;
    expv = (rst_m || !en_m) ? 1'b1 : ((cyc - zero >= T) ? 1'b0 : 1'b1);
    checks++;
    if (wdo_n !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d wdo_n=%0b expected %0b", tag, cyc, wdo_n, expv);
    end
  endtask

  task automatic run(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(tag);
    end
  endtask

  task automatic kick(input string tag);
    kick_in = ~kick_in;
    run(2, "R9");
    zero = cyc + 1;
    run(1, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog timer expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    run(4, "R7");
    rst = 1'b0; rst_m = 1'b0; zero = cyc;
    run(T + 3, "R3");
    run(2 * T, "R4");
    run(3, "R5");
    for (int g = 0; g <= 2 * T + 1; g++) begin
      if (kick_in == 1'b0) kick("R1"); else kick("R2");
      run(g, (g >= T) ? "R5" : "R3");
    end
    kick("R1");
    run(T - 3, "R3");
    kick("R8");
    run(T + 1, "R8");
    run(T, "R5");
    enable = 1'b0; en_m = 1'b0;
    run(3 * T, "R6");
    enable = 1'b1; en_m = 1'b1; zero = cyc;
    run(T + 2, "R6");
    kick("R2");
    run(2, "R1");
    rst = 1'b1; rst_m = 1'b1;
    run(3, "R7");
    rst = 1'b0; rst_m = 1'b0; zero = cyc;
    run(T + 2, "R7");
    finish_run();
  end
endmodule